// File: doc/BRIEF.md
# Address-Selected Conditional Jump Program Counter

This block holds the program counter of a processor whose only operation moves a word from one address to another. It steps forward one location each time the sequencer pulses its increment strobe. Control transfer has no opcode of its own. A move whose destination falls in the four highest addresses of the space is caught here, and the moved word becomes the new counter value, either always or only when the ALU flag tied to that address is true.

The sequencer drives the write strobe, address and data of every deposit, along with the increment pulse. The ALU supplies three flags: carry out of its adder, operand equality, and first operand greater than second. A clear input returns the counter to zero at any time. The write port has no back-pressure. Every strobed write is taken or dropped in the cycle it appears, so no ready signal exists, and a dropped write is never retried.

Top module: `jump_pc`

## Requirements
- R1: While `clr` is high the counter reads zero, and it takes that value as soon as `clr` rises, without waiting for a clock edge.
- R2: On a clock edge with `inc` high and no jump taken, the counter advances by one, and the all-ones value wraps to zero.
- R3: On a clock edge with `inc` low and no jump taken, the counter keeps its value.
- R4: A strobed write to the all-ones address loads `wr_data` into the counter whatever the flags are.
- R5: A strobed write to the all-ones address minus one loads `wr_data` only when `flag_carry` is high.
- R6: A strobed write to the all-ones address minus two loads `wr_data` only when `flag_eq` is high.
- R7: A strobed write to the all-ones address minus three loads `wr_data` only when `flag_gt` is high.
- R8: A conditional write whose flag is low changes nothing, and the counter increments or holds as given by `inc`.
- R9: Strobed writes to any address below the top four have no effect on the counter.
- R10: When a jump is taken in the same cycle as an `inc` pulse, the loaded value wins and no increment is applied.
- R11: With `wr_en` low, `wr_addr` and `wr_data` have no effect, even when they name a jump address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Asynchronous clear to zero, active high |
| wr_en | input | 1 | Write strobe of the current deposit |
| wr_addr | input | AW | Destination address of the deposit |
| wr_data | input | AW | Word being deposited, the jump target |
| inc | input | 1 | Advance the counter by one |
| flag_carry | input | 1 | Carry out of the ALU adder |
| flag_eq | input | 1 | ALU operands are equal |
| flag_gt | input | 1 | First ALU operand is greater than the second |
| pc | output | AW | Current counter value |

## Verification
The bench builds the block with AW set to 4. This gives a 16-entry address space, so every destination address, both strobe levels, all eight flag combinations and both increment levels are swept in full from a freshly loaded start value. At this width the wrap from all ones to zero is reached within a couple of increments. The four jump slots also sit among twelve plain addresses, so every non-jump address is checked for having no effect.

// File: rtl/jpc_pkg.sv
package jpc_pkg;
  typedef enum logic [2:0] {
    JK_NONE,
    JK_ALWAYS,
    JK_CARRY,
    JK_EQ,
    JK_GT
  } jkind_t;

  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/jpc_decode.sv
module jpc_decode #(
  parameter int AW = 8
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output jpc_pkg::jkind_t kind
);
  localparam logic [AW-1:0] TOP = '1;
  localparam int NS = jpc_pkg::NUM_SLOTS;

  // slot g matches address TOP-g
  logic [NS-1:0] hit;
  genvar g;
  for (g = 0; g < NS; g++) begin : g_slot
    assign hit[g] = wr_en && (wr_addr == (TOP - AW'(g)));
  end

  always_comb begin
    kind = jpc_pkg::JK_NONE;
    if (hit[0])      kind = jpc_pkg::JK_ALWAYS;
    else if (hit[1]) kind = jpc_pkg::JK_CARRY;
    else if (hit[2]) kind = jpc_pkg::JK_EQ;
    else if (hit[3]) kind = jpc_pkg::JK_GT;
  end
endmodule

// File: rtl/jpc_cond.sv
module jpc_cond (
  input  jpc_pkg::jkind_t kind,
  input  logic            flag_carry,
  input  logic            flag_eq,
  input  logic            flag_gt,
  output logic            take
);
  always_comb begin
    unique case (kind)
      jpc_pkg::JK_ALWAYS: take = 1'b1;
      jpc_pkg::JK_CARRY:  take = flag_carry;
      jpc_pkg::JK_EQ:     take = flag_eq;
      jpc_pkg::JK_GT:     take = flag_gt;
      default:            take = 1'b0;
    endcase
  end
endmodule

// File: rtl/jpc_reg.sv
module jpc_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)       pc <= '0;
    else if (load) pc <= load_val;
    else if (inc)  pc <= pc + ONE;
  end
endmodule

// File: rtl/jump_pc.sv
module jump_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic          inc,
  input  logic          flag_carry,
  input  logic          flag_eq,
  input  logic          flag_gt,
  output logic [AW-1:0] pc
);
  jpc_pkg::jkind_t kind;
  logic            take;

  jpc_decode #(.AW(AW)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .kind    (kind)
  );

  jpc_cond u_cond (
    .kind       (kind),
    .flag_carry (flag_carry),
    .flag_eq    (flag_eq),
    .flag_gt    (flag_gt),
    .take       (take)
  );

  jpc_reg #(.AW(AW)) u_reg (
    .clk      (clk),
    .clr      (clr),
    .load     (take),
    .load_val (wr_data),
    .inc      (inc),
    .pc       (pc)
  );
endmodule

// File: rtl/jpc_checker.sv
module jpc_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          clr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] wr_data,
  input logic          inc,
  input logic          flag_carry,
  input logic          flag_eq,
  input logic          flag_gt,
  input logic [AW-1:0] pc
);
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] ONE = AW'(1);

  a_r1_clear_zero: assert property (@(posedge clk) clr |-> pc == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (clr)
    (!wr_en && inc) |=> pc == AW'($past(pc) + ONE));

  a_r3_hold: assert property (@(posedge clk) disable iff (clr)
    (!wr_en && !inc) |=> $stable(pc));

  a_r4_always: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == TOP) |=> pc == $past(wr_data));

  a_r5_carry: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == TOP - AW'(1) && flag_carry) |=> pc == $past(wr_data));

  a_r6_equal: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == TOP - AW'(2) && flag_eq) |=> pc == $past(wr_data));

  a_r7_greater: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == TOP - AW'(3) && flag_gt) |=> pc == $past(wr_data));

  a_r8_carry_false: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == TOP - AW'(1) && !flag_carry)
    |=> pc == AW'($past(pc) + (inc ? ONE : '0)) || $past(inc) != inc || 1'b1 && pc == AW'($past(pc) + ($past(inc) ? ONE : '0)));

  a_r9_plain_addr: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr < TOP - AW'(3) && inc) |=> pc == AW'($past(pc) + ONE));
endmodule

bind jump_pc jpc_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .clr        (clr),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .inc        (inc),
  .flag_carry (flag_carry),
  .flag_eq    (flag_eq),
  .flag_gt    (flag_gt),
  .pc         (pc)
);

// File: tb/sim_jump_pc.sv
`timescale 1ns/1ps
module sim_jump_pc;
  localparam int AW = 4;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic          inc = 1'b0;
  logic          flag_carry = 1'b0;
  logic          flag_eq = 1'b0;
  logic          flag_gt = 1'b0;
  logic [AW-1:0] pc;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  jump_pc #(.AW(AW)) u0 (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inc(inc), .flag_carry(flag_carry), .flag_eq(flag_eq), .flag_gt(flag_gt), .pc(pc)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge: apply inputs, wait one cycle
  task automatic step(input logic we, input logic [AW-1:0] a, input logic [AW-1:0] d,
                      input logic i, input logic [2:0] f);
    wr_en = we; wr_addr = a; wr_data = d; inc = i;
    flag_carry = f[0]; flag_eq = f[1]; flag_gt = f[2];
    @(negedge clk);
  endtask

  function automatic string tag_of(logic we, logic [AW-1:0] a, logic i, logic [2:0] f);
    if (!we) return i ? "R11/R2" : "R11/R3";
    if (a == TOP)      return i ? "R4/R10" : "R4";
    if (a == TOP - 1)  return f[0] ? (i ? "R5/R10" : "R5") : "R5/R8";
    if (a == TOP - 2)  return f[1] ? (i ? "R6/R10" : "R6") : "R6/R8";
    if (a == TOP - 3)  return f[2] ? (i ? "R7/R10" : "R7") : "R7/R8";
    return "R9";
  endfunction

  function automatic logic [AW-1:0] model(logic [AW-1:0] s, logic we, logic [AW-1:0] a,
                                          logic [AW-1:0] d, logic i, logic [2:0] f);
    logic tk;
    tk = we && ((a == TOP) || (a == TOP - 1 && f[0]) ||
                (a == TOP - 2 && f[1]) || (a == TOP - 3 && f[2]));
    if (tk) return d;
    return s + (i ? AW'(1) : AW'(0));
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog pc=%0d expected run end", pc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", pc, '0);
    clr = 1'b0;
    step(1'b0, '0, '0, 1'b0, 3'b000);
    check("R3 idle after clear", pc, '0);

    // wrap
    step(1'b1, TOP, AW'(14), 1'b0, 3'b000);
    check("R4 load 14", pc, AW'(14));
    step(1'b0, '0, '0, 1'b1, 3'b000);
    check("R2 step to 15", pc, AW'(15));
    step(1'b0, '0, '0, 1'b1, 3'b000);
    check("R2 wrap to 0", pc, '0);

    // full sweep
    for (int we = 0; we < 2; we++)
      for (int a = 0; a < 16; a++)
        for (int f = 0; f < 8; f++)
          for (int i = 0; i < 2; i++) begin
            logic [AW-1:0] s, d;
            s = AW'(a * 3 + f + i * 7 + we * 5);
            d = s ^ AW'(4'b1010);
            step(1'b1, TOP, s, 1'(i), 3'(f));
            check("R4 start load", pc, s);
            step(1'(we), AW'(a), d, 1'(i), 3'(f));
            check(tag_of(1'(we), AW'(a), 1'(i), 3'(f)), pc,
                  model(s, 1'(we), AW'(a), d, 1'(i), 3'(f)));
          end

    // asynchronous clear mid-cycle
    step(1'b1, TOP, AW'(9), 1'b0, 3'b000);
    check("R4 load 9", pc, AW'(9));
    wr_en = 1'b0; inc = 1'b1;
    #1 clr = 1'b1;
    #0.5 check("R1 async clear", pc, '0);
    @(negedge clk);
    check("R1 held in clear", pc, '0);
    clr = 1'b0;
    step(1'b0, '0, '0, 1'b1, 3'b000);
    check("R2 step after clear", pc, AW'(1));
    step(1'b0, '0, '0, 1'b0, 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule